// File: doc/BRIEF.md
# I2C Master Bit-Level Bus-Condition Timer

This block produces the clock (SCL) and data (SDA) line levels of an I2C master one bus event at a time. A controller above it hands over a stream of commands: start (or repeated start), write one bit, read one bit, stop. For each command the block plays out a short series of line segments whose lengths are counted in peripheral clock cycles. SCL high and low phases are built from two programmable dividers. Each phase is a multiple of eight cycles.

A rule-select input picks one of two edge placement schemes. In the legacy scheme, start, stop and data-change points sit at fixed fractions of the phases: seven eighths of the high phase, and half of the low phase. In the extended scheme, separate counts set the start setup, the start hold and the stop setup. A position value places the data change at any eighth of the low phase. The block latches all timing inputs when it accepts a command, so software can rewrite them at any time.

Commands arrive on a valid/ready channel. The block raises `cmd_ready` only while it is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the command has finished, and this is the only back-pressure. The block holds no queue. Completion is a one-cycle `done` pulse. For a read, the sampled bit is presented on `rd_bit` at the same time. Line outputs are levels, where 1 means the line is released.

Top module: `i2c_bitgen`

## Requirements
- R1: After reset, `scl_o`=1, `sda_o`=1, `cmd_ready`=1 and `done`=0, and the bus counts as free.
- R2: A write bit (`cmd_op`=2'b01) keeps SCL low for 8·divl cycles, then high for 8·divh cycles. SDA takes the value of `cmd_wbit` at the data-change point and holds it through the high phase. SDA never changes on a cycle where SCL rises or falls.
- R3: With `mode_new`=0, SDA changes 4·divl cycles into the low phase. The new value is then held for the remaining 4·divl cycles.
- R4: With `mode_new`=1, SDA changes n·divl cycles into the low phase, where n = `upd_pos` (3 bits). A value of 0 acts as 1.
- R5: With `mode_new`=0, a start (`cmd_op`=2'b00) holds SCL high with SDA released for 7·divh+1 cycles, then drives SDA low for 14·divh−1 cycles. The count inputs have no effect in this mode.
- R6: With `mode_new`=1, the start setup (SCL high, SDA released) lasts 8·divh·s+1 cycles, where s = `su_cnt`, and 0 acts as 1.
- R7: With `mode_new`=1, the start hold (SDA low, SCL high) lasts 8·divh·(u+1)−1 cycles, where u = `hd_cnt`.
- R8: A stop (`cmd_op`=2'b11) has a low phase with SDA driven low. It then holds SCL high with SDA low for 7·divh+1 cycles (legacy) or 8·divh·p+1 cycles (extended, p = `sp_cnt`, 0 acts as 1). SDA is then released for one cycle before completion, and the bus counts as free.
- R9: A start on a free bus begins directly with its setup segment. A start on a busy bus (repeated start) first runs a low phase. In that low phase SDA is released at the data-change point.
- R10: A read bit (`cmd_op`=2'b10) releases SDA at the data-change point. It samples `sda_i` on the edge where SCL rises, and shows the sample on `rd_bit` while `done` is high.
- R11: `cmd_ready` is high only while idle. After acceptance there is one cycle with no line change, then the segments follow. `done` is high for exactly one cycle after the last segment, with the lines holding the last segment's levels.
- R12: Divider, count, position and mode inputs are captured when the command is accepted. Changing them while a command runs does not change that command's waveform.
- R13: A divider value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_new | input | 1 | 1 selects the extended rule set, 0 the legacy one |
| div_high | input | DIV_W | High phase divider (phase = 8·value) |
| div_low | input | DIV_W | Low phase divider (phase = 8·value) |
| su_cnt | input | CNT_W | Start setup count, extended mode |
| hd_cnt | input | CNT_W | Start hold count, extended mode |
| sp_cnt | input | CNT_W | Stop setup count, extended mode |
| upd_pos | input | 3 | Data-change position in eighths of the low phase, extended mode |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 00 start, 01 write, 10 read, 11 stop |
| cmd_wbit | input | 1 | Bit value for a write |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Bit sampled by the last read |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level (1 = released) |
| sda_i | input | 1 | Sensed SDA line |

## Verification
The bench builds the block with DIV_W=4 and CNT_W=3. This brings zero and all-ones dividers and counts within reach at short segment lengths, so random commands can sweep both rule sets, every data-change position and the clamped zero cases. Each segment is checked cycle by cycle against durations the bench computes from the formulas above. Further checks cover free-bus starts against repeated starts, read sampling for both line values, and configuration rewrites while a command is running.

// File: rtl/i2c_bitgen_pkg.sv
package i2c_bitgen_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_STOP  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } st_e;

  localparam int SEG_IDX_W = 2;
  localparam int POS_W     = 3;
endpackage

// File: rtl/i2c_bitgen_cfg.sv
// Captures timing inputs on command acceptance and applies the zero clamps.
module i2c_bitgen_cfg #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          mode_in,
  input  logic [DIV_W-1:0]              divh_in,
  input  logic [DIV_W-1:0]              divl_in,
  input  logic [CNT_W-1:0]              su_in,
  input  logic [CNT_W-1:0]              hd_in,
  input  logic [CNT_W-1:0]              sp_in,
  input  logic [i2c_bitgen_pkg::POS_W-1:0] pos_in,
  output logic                          mode_q,
  output logic [DIV_W-1:0]              divh_q,
  output logic [DIV_W-1:0]              divl_q,
  output logic [CNT_W-1:0]              su_q,
  output logic [CNT_W-1:0]              hd_q,
  output logic [CNT_W-1:0]              sp_q,
  output logic [i2c_bitgen_pkg::POS_W-1:0] pos_q
);
  import i2c_bitgen_pkg::*;

  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      divh_q <= DIV_ONE;
      divl_q <= DIV_ONE;
      su_q   <= CNT_ONE;
      hd_q   <= '0;
      sp_q   <= CNT_ONE;
      pos_q  <= POS_ONE;
    end else if (load) begin
      mode_q <= mode_in;
      divh_q <= (divh_in == '0) ? DIV_ONE : divh_in;
      divl_q <= (divl_in == '0) ? DIV_ONE : divl_in;
      su_q   <= (su_in == '0) ? CNT_ONE : su_in;
      hd_q   <= hd_in;
      sp_q   <= (sp_in == '0) ? CNT_ONE : sp_in;
      pos_q  <= (pos_in == '0) ? POS_ONE : pos_in;
    end
  end
endmodule

// File: rtl/i2c_bitgen_calc.sv
// Converts latched settings into segment lengths for the chosen rule set.
module i2c_bitgen_calc #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 4,
  parameter int DUR_W = DIV_W + CNT_W + 4
) (
  input  logic                             mode,
  input  logic [DIV_W-1:0]                 divh,
  input  logic [DIV_W-1:0]                 divl,
  input  logic [CNT_W-1:0]                 su,
  input  logic [CNT_W-1:0]                 hd,
  input  logic [CNT_W-1:0]                 sp,
  input  logic [i2c_bitgen_pkg::POS_W-1:0] pos,
  output logic [DUR_W-1:0]                 t_high,
  output logic [DUR_W-1:0]                 t_low,
  output logic [DUR_W-1:0]                 t_chg,
  output logic [DUR_W-1:0]                 t_su,
  output logic [DUR_W-1:0]                 t_hd,
  output logic [DUR_W-1:0]                 t_sp
);
  localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

  logic [DUR_W-1:0] dh, dl, unit_h, seven_h;

  always_comb begin
    dh      = DUR_W'(divh);
    dl      = DUR_W'(divl);
    unit_h  = dh << 3;
    seven_h = unit_h - dh;
    t_high  = unit_h;
    t_low   = dl << 3;
    if (mode) begin
      t_chg = DUR_W'(pos) * dl;
      t_su  = unit_h * DUR_W'(su) + ONE;
      t_hd  = unit_h * (DUR_W'(hd) + ONE) - ONE;
      t_sp  = unit_h * DUR_W'(sp) + ONE;
    end else begin
      t_chg = dl << 2;
      t_su  = seven_h + ONE;
      t_hd  = (seven_h << 1) - ONE;
      t_sp  = seven_h + ONE;
    end
  end
endmodule

// File: rtl/i2c_bitgen_cnt.sv
// Segment down-counter: reload on demand, flag the final cycle.
module i2c_bitgen_cnt #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  output logic             last
);
  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - DUR_W'(1);
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/i2c_bitgen_seq.sv
// Command sequencer: walks up to four line segments per command.
module i2c_bitgen_seq #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_wbit,
  input  logic             sda_i,
  input  logic [DUR_W-1:0] t_high,
  input  logic [DUR_W-1:0] t_low,
  input  logic [DUR_W-1:0] t_chg,
  input  logic [DUR_W-1:0] t_su,
  input  logic [DUR_W-1:0] t_hd,
  input  logic [DUR_W-1:0] t_sp,
  input  logic             seg_last,
  output logic             cfg_load,
  output logic             cnt_load,
  output logic [DUR_W-1:0] cnt_val,
  output logic             done,
  output logic             rd_bit,
  output logic             scl_o,
  output logic             sda_o
);
  import i2c_bitgen_pkg::*;

  st_e                  st_q;
  op_e                  op_q;
  logic                 wbit_q, free_q, done_q, rd_q, scl_q, sda_q;
  logic [SEG_IDX_W-1:0] idx_q, nxt_idx, end_idx;
  logic                 advance, finish, accept;
  logic                 seg_scl, seg_sda, mid_sda;
  logic [DUR_W-1:0]     seg_dur;

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign cfg_load  = accept;

  assign end_idx = (op_q == OP_WRITE || op_q == OP_READ) ? SEG_IDX_W'(2) : SEG_IDX_W'(3);
  assign finish  = (st_q == ST_RUN) && seg_last && (idx_q == end_idx);
  assign advance = (st_q == ST_LOAD) || ((st_q == ST_RUN) && seg_last && (idx_q != end_idx));

  always_comb begin
    if (st_q == ST_LOAD)
      nxt_idx = (op_q == OP_START && free_q) ? SEG_IDX_W'(2) : SEG_IDX_W'(0);
    else
      nxt_idx = idx_q + SEG_IDX_W'(1);
  end

  // Level SDA takes after the data-change point of the low phase.
  always_comb begin
    unique case (op_q)
      OP_START: mid_sda = 1'b1;
      OP_WRITE: mid_sda = wbit_q;
      OP_READ:  mid_sda = 1'b1;
      default:  mid_sda = 1'b0;
    endcase
  end

  // Segment table for the segment about to be entered.
  always_comb begin
    seg_scl = 1'b1;
    seg_sda = sda_q;
    seg_dur = DUR_W'(1);
    unique case (nxt_idx)
      2'd0: begin
        seg_scl = 1'b0;
        seg_sda = sda_q;
        seg_dur = t_chg;
      end
      2'd1: begin
        seg_scl = 1'b0;
        seg_sda = mid_sda;
        seg_dur = t_low - t_chg;
      end
      2'd2: begin
        seg_scl = 1'b1;
        seg_sda = mid_sda;
        if (op_q == OP_START)     seg_dur = t_su;
        else if (op_q == OP_STOP) seg_dur = t_sp;
        else                      seg_dur = t_high;
      end
      default: begin
        seg_scl = 1'b1;
        seg_sda = (op_q == OP_STOP);
        seg_dur = (op_q == OP_START) ? t_hd : DUR_W'(1);
      end
    endcase
  end

  assign cnt_load = advance;
  assign cnt_val  = seg_dur - DUR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_STOP;
      wbit_q <= 1'b0;
      free_q <= 1'b1;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      idx_q  <= '0;
    end else begin
      done_q <= finish;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_LOAD;
          op_q   <= op_e'(cmd_op);
          wbit_q <= cmd_wbit;
        end
        ST_LOAD: st_q <= ST_RUN;
        default: if (finish) begin
          st_q   <= ST_IDLE;
          free_q <= (op_q == OP_STOP);
        end
      endcase
      if (advance) begin
        idx_q <= nxt_idx;
        scl_q <= seg_scl;
        sda_q <= seg_sda;
        if (op_q == OP_READ && nxt_idx == 2'd2) rd_q <= sda_i;
      end
    end
  end

  assign done   = done_q;
  assign rd_bit = rd_q;
  assign scl_o  = scl_q;
  assign sda_o  = sda_q;
endmodule

// File: rtl/i2c_bitgen.sv
module i2c_bitgen #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_new,
  input  logic [DIV_W-1:0] div_high,
  input  logic [DIV_W-1:0] div_low,
  input  logic [CNT_W-1:0] su_cnt,
  input  logic [CNT_W-1:0] hd_cnt,
  input  logic [CNT_W-1:0] sp_cnt,
  input  logic [2:0]       upd_pos,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_wbit,
  output logic             done,
  output logic             rd_bit,
  output logic             scl_o,
  output logic             sda_o,
  input  logic             sda_i
);
  import i2c_bitgen_pkg::*;

  localparam int DUR_W = DIV_W + CNT_W + 4;

  logic             cfg_load, cnt_load, seg_last, m_q;
  logic [DIV_W-1:0] dh_q, dl_q;
  logic [CNT_W-1:0] su_q, hd_q, sp_q;
  logic [POS_W-1:0] pos_q;
  logic [DUR_W-1:0] t_high, t_low, t_chg, t_su, t_hd, t_sp, cnt_val;

  i2c_bitgen_cfg #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .mode_in(mode_new), .divh_in(div_high), .divl_in(div_low),
    .su_in(su_cnt), .hd_in(hd_cnt), .sp_in(sp_cnt), .pos_in(upd_pos),
    .mode_q(m_q), .divh_q(dh_q), .divl_q(dl_q),
    .su_q(su_q), .hd_q(hd_q), .sp_q(sp_q), .pos_q(pos_q)
  );

  i2c_bitgen_calc #(.DIV_W(DIV_W), .CNT_W(CNT_W), .DUR_W(DUR_W)) u_calc (
    .mode(m_q), .divh(dh_q), .divl(dl_q), .su(su_q), .hd(hd_q), .sp(sp_q), .pos(pos_q),
    .t_high(t_high), .t_low(t_low), .t_chg(t_chg),
    .t_su(t_su), .t_hd(t_hd), .t_sp(t_sp)
  );

  i2c_bitgen_cnt #(.DUR_W(DUR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .last(seg_last)
  );

  i2c_bitgen_seq #(.DUR_W(DUR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wbit(cmd_wbit),
    .sda_i(sda_i),
    .t_high(t_high), .t_low(t_low), .t_chg(t_chg), .t_su(t_su), .t_hd(t_hd), .t_sp(t_sp),
    .seg_last(seg_last), .cfg_load(cfg_load), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .done(done), .rd_bit(rd_bit), .scl_o(scl_o), .sda_o(sda_o)
  );
endmodule

// File: rtl/i2c_bitgen_chk.sv
module i2c_bitgen_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic done,
  input logic scl_o,
  input logic sda_o
);
  // R11: completion pulse lasts one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: completion is reported only when idle
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R11: acceptance makes the block busy on the next cycle
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R2: SDA is steady on the cycle SCL rises
  a_r2_sda_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_o) |-> $stable(sda_o));

  // R2: SDA is steady on the cycle SCL falls
  a_r2_sda_steady_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> $stable(sda_o));
endmodule

bind i2c_bitgen i2c_bitgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .scl_o(scl_o), .sda_o(sda_o)
);

// File: tb/i2c_bitgen_test.sv
`timescale 1ns/1ps
module i2c_bitgen_test;
  localparam int DW = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_new;
  logic [DW-1:0] div_high, div_low;
  logic [CW-1:0] su_cnt, hd_cnt, sp_cnt;
  logic [2:0]    upd_pos;
  logic          cmd_valid, cmd_ready, cmd_wbit, done, rd_bit, scl_o, sda_o, sda_i;
  logic [1:0]    cmd_op;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic exp_sda;
  bit   exp_free;

  always #2.5 clk = ~clk;

  i2c_bitgen #(.DIV_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_new(mode_new), .div_high(div_high), .div_low(div_low),
    .su_cnt(su_cnt), .hd_cnt(hd_cnt), .sp_cnt(sp_cnt), .upd_pos(upd_pos),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wbit(cmd_wbit),
    .done(done), .rd_bit(rd_bit), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
  );

  function automatic int clamp1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(bit m, int dh, int dl, int s, int u, int p, int n);
    mode_new = m;
    div_high = DW'(dh);
    div_low  = DW'(dl);
    su_cnt   = CW'(s);
    hd_cnt   = CW'(u);
    sp_cnt   = CW'(p);
    upd_pos  = 3'(n);
  endtask

  task automatic rand_cfg();
    set_cfg(bit'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom_range(0, 15),
            $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 7));
  endtask

  // Issue one command at a negedge with cmd_ready high; check every cycle of it.
  task automatic run_cmd(logic [1:0] op, logic b, logic rdin, bit scramble, string note);
    int   dh, dl, hi, lo, dc, tsu, thd, tsp, first, last;
    bit   m;
    logic s_scl[4];
    logic s_sda[4];
    int   s_dur[4];
    string s_tag[4];
    m   = mode_new;
    dh  = clamp1(int'(div_high));
    dl  = clamp1(int'(div_low));
    hi  = 8 * dh;
    lo  = 8 * dl;
    dc  = m ? clamp1(int'(upd_pos)) * dl : 4 * dl;
    tsu = m ? 8 * dh * clamp1(int'(su_cnt)) + 1 : 7 * dh + 1;
    thd = m ? 8 * dh * (int'(hd_cnt) + 1) - 1 : 14 * dh - 1;
    tsp = m ? 8 * dh * clamp1(int'(sp_cnt)) + 1 : 7 * dh + 1;
    s_scl[0] = 1'b0; s_sda[0] = exp_sda; s_dur[0] = dc;      s_tag[0] = m ? "R4" : "R3";
    s_scl[1] = 1'b0; s_dur[1] = lo - dc;                     s_tag[1] = m ? "R4" : "R3";
    case (op)
      2'b00:   s_sda[1] = 1'b1;
      2'b01:   s_sda[1] = b;
      2'b10:   s_sda[1] = 1'b1;
      default: s_sda[1] = 1'b0;
    endcase
    s_scl[2] = 1'b1; s_sda[2] = s_sda[1];
    s_dur[2] = (op == 2'b00) ? tsu : (op == 2'b11) ? tsp : hi;
    s_tag[2] = (op == 2'b00) ? (m ? "R6" : "R5") : (op == 2'b11) ? "R8" : "R2";
    s_scl[3] = 1'b1; s_sda[3] = (op == 2'b11);
    s_dur[3] = (op == 2'b00) ? thd : 1;
    s_tag[3] = (op == 2'b00) ? (m ? "R7" : "R5") : "R8";
    first = (op == 2'b00 && exp_free) ? 2 : 0;
    if (op == 2'b00) begin
      s_tag[0] = "R9";
      s_tag[1] = "R9";
    end
    last  = (op == 2'b01 || op == 2'b10) ? 2 : 3;

    check(cmd_ready === 1'b1, "R11", {note, " ready before issue"}, int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_wbit = b; sda_i = rdin;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready === 1'b0, "R11", {note, " busy after accept"}, int'(cmd_ready), 0);
    check(sda_o === exp_sda, "R11", {note, " no change in load cycle"}, int'(sda_o), int'(exp_sda));
    if (scramble) rand_cfg();  // R12: rewrite settings mid-command
    for (int k = first; k <= last; k++) begin
      bit ok = 1'b1;
      int got = 0;
      int cyc = -1;
      for (int c = 0; c < s_dur[k]; c++) begin
        @(negedge clk);
        if (ok && (scl_o !== s_scl[k] || sda_o !== s_sda[k] || done !== 1'b0)) begin
          ok  = 1'b0;
          got = {29'd0, done, scl_o, sda_o};
          cyc = c;
        end
      end
      check(ok, s_tag[k], $sformatf("%s seg%0d len%0d first bad cycle %0d {done,scl,sda}", note, k, s_dur[k], cyc),
            got, int'({s_scl[k], s_sda[k]}));
    end
    @(negedge clk);
    check(done === 1'b1, "R11", {note, " done after last segment"}, int'(done), 1);
    check(scl_o === s_scl[last] && sda_o === s_sda[last], "R11", {note, " levels held at done"},
          int'({scl_o, sda_o}), int'({s_scl[last], s_sda[last]}));
    if (op == 2'b10)
      check(rd_bit === rdin, "R10", {note, " read sample"}, int'(rd_bit), int'(rdin));
    exp_sda  = s_sda[last];
    exp_free = (op == 2'b11);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R11 watchdog: got no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_wbit = 1'b0; sda_i = 1'b1;
    set_cfg(1'b0, 3, 2, 0, 0, 0, 0);
    exp_sda = 1'b1; exp_free = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(scl_o === 1'b1, "R1", "scl after reset", int'(scl_o), 1);
    check(sda_o === 1'b1, "R1", "sda after reset", int'(sda_o), 1);
    check(cmd_ready === 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
    check(done === 1'b0, "R1", "done after reset", int'(done), 0);

    // Legacy rules, directed bits
    run_cmd(2'b00, 1'b0, 1'b1, 1'b0, "R9 free start legacy");
    run_cmd(2'b01, 1'b0, 1'b1, 1'b0, "R2 write0");
    run_cmd(2'b01, 1'b1, 1'b1, 1'b0, "R2 write1");
    run_cmd(2'b10, 1'b0, 1'b0, 1'b0, "R10 read0");
    run_cmd(2'b10, 1'b0, 1'b1, 1'b0, "R10 read1");
    run_cmd(2'b00, 1'b0, 1'b1, 1'b0, "R9 repeated start");
    run_cmd(2'b11, 1'b0, 1'b1, 1'b0, "R8 stop legacy");
    // R5: counts at their maximum have no effect in legacy mode
    set_cfg(1'b0, 2, 5, 7, 7, 7, 7);
    run_cmd(2'b00, 1'b0, 1'b1, 1'b0, "R5 counts ignored");
    run_cmd(2'b01, 1'b1, 1'b1, 1'b0, "R5 counts ignored");
    run_cmd(2'b11, 1'b0, 1'b1, 1'b0, "R5 counts ignored");
    // Extended rules at the zero clamps
    set_cfg(1'b1, 2, 3, 0, 0, 0, 0);
    run_cmd(2'b00, 1'b0, 1'b1, 1'b0, "R6 R7 zero counts");
    run_cmd(2'b01, 1'b0, 1'b1, 1'b0, "R4 pos zero");
    run_cmd(2'b11, 1'b0, 1'b1, 1'b0, "R8 stop zero count");
    // Extended rules, larger counts and last position
    set_cfg(1'b1, 1, 4, 3, 2, 5, 7);
    run_cmd(2'b00, 1'b0, 1'b1, 1'b0, "R6 R7 counts");
    run_cmd(2'b01, 1'b1, 1'b1, 1'b0, "R4 pos7");
    run_cmd(2'b10, 1'b0, 1'b0, 1'b0, "R10 read ext");
    run_cmd(2'b00, 1'b0, 1'b1, 1'b0, "R9 repeated ext");
    run_cmd(2'b11, 1'b0, 1'b1, 1'b0, "R8 stop ext");
    // R13: zero dividers
    set_cfg(1'b0, 0, 0, 0, 0, 0, 0);
    run_cmd(2'b00, 1'b0, 1'b1, 1'b0, "R13 div0");
    run_cmd(2'b01, 1'b0, 1'b1, 1'b0, "R13 div0");
    set_cfg(1'b1, 0, 0, 1, 1, 1, 4);
    run_cmd(2'b11, 1'b0, 1'b1, 1'b0, "R13 div0 ext");
    // R12: settings rewritten while commands run
    set_cfg(1'b1, 3, 3, 2, 1, 2, 5);
    run_cmd(2'b00, 1'b0, 1'b1, 1'b1, "R12 scramble");
    run_cmd(2'b01, 1'b1, 1'b1, 1'b1, "R12 scramble");
    run_cmd(2'b11, 1'b0, 1'b1, 1'b1, "R12 scramble");
    // Random mix
    for (int i = 0; i < 100; i++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic b = 1'($urandom_range(0, 1));
      logic r = 1'($urandom_range(0, 1));
      bit scr = ($urandom_range(0, 3) == 0);
      rand_cfg();
      run_cmd(op, b, r, scr, "random");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule